// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by reading page table entries from memory one level at a time. A two-level scheme (32-bit virtual space, 10-bit indices, 4-byte entries) and a three-level scheme (39-bit virtual space, 9-bit indices, 8-byte entries) are selected per request. A bare setting passes addresses through untranslated. Each request carries the access kind (fetch, load or store), the effective privilege, a flag that lets supervisor code touch user pages, and a flag that makes execute-only pages readable.

The walker owns the full leaf check: reserved encodings, privilege, superpage alignment and access rights. On success it sets the accessed flag, and the dirty flag for stores, and writes the entry back through the same memory port only when the value changes. The response carries either a fault, tagged with the request's access kind so the caller can pick a page-fault cause, or a physical address plus read, write and execute permissions suitable for filling a translation cache.

Top module: `pt_walker`

## Requirements
- R1: When the mode code is neither 1 (two-level) nor 2 (three-level), or the privilege code is 3 (machine), the response carries the low address bits of the virtual address unchanged, all three permissions set, no fault, and no memory access is made.
- R2: In three-level mode, virtual address bits 63 down to 38 must all be equal, else the request faults with no memory access. In two-level mode, bits above 31 are ignored.
- R3: Each entry is read from table base times 4096 plus index times entry size. The walk starts at the top level: two-level indices are va[31:22] then va[21:12], and three-level indices are va[38:30], va[29:21] and va[20:12]. The first base is rootPpn. Entry flags are V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6 and D bit 7. The page number starts at bit 10, and two-level entries use only bits 31:0.
- R4: An entry with V clear faults. A valid entry with R, W and X all clear points to the next table, whose base is its page number. Such a pointer at the last level faults.
- R5: A leaf with W set and R clear faults. This covers W alone and W with X.
- R6: A leaf with U set faults when the privilege is not user (0) and either the supervisor-user flag is clear or the access is a fetch. A leaf with U clear faults when the privilege is not supervisor (1).
- R7: A leaf found above the last level faults if the page-number bits covering the skipped levels are not all zero.
- R8: A load needs R, or X with the execute-readable flag set. A store needs W. A fetch needs X. Otherwise the request faults. Access codes are 0 fetch, 1 load and 2 store.
- R9: On success the entry is written back, at the address it was read from, with A set and with D also set for stores. The write is skipped when the value would not change.
- R10: The physical address is the leaf page number, with its skipped-level bits taken from the virtual page number, followed by the 12-bit page offset.
- R11: A translated response grants read for R, or for X with the execute-readable flag. It grants execute for X, and write for W when the access is a store or D was already set. A faulting response grants nothing.
- R12: rspAccess on every response equals the access code of the request.
- R13: reqReady is high only while idle. rspValid is a one-cycle pulse. memReq holds with a stable address, write enable and write data until memReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; taken when reqReady is high |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | VA_W | Virtual address |
| reqAccess | input | 2 | 0 fetch, 1 load, 2 store |
| reqPriv | input | 2 | 0 user, 1 supervisor, 3 machine |
| reqSupUser | input | 1 | Supervisor may access user pages (not for fetch) |
| reqExecRead | input | 1 | Execute-only pages are readable by loads |
| walkMode | input | 2 | 0 bare, 1 two-level, 2 three-level |
| rootPpn | input | PA_W-12 | Page number of the top-level table |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write of memWdata |
| memAddr | output | PA_W | Byte address of the entry |
| memWdata | output | PTE_W | Updated entry for write-back |
| memReady | input | 1 | Memory completes the access this cycle |
| memRdata | input | PTE_W | Entry read, valid with memReady |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 1 | Translation faulted |
| rspAccess | output | 2 | Access code of the answered request |
| rspPaddr | output | PA_W | Physical address |
| rspRead | output | 1 | Read permission |
| rspWrite | output | 1 | Write permission |
| rspExec | output | 1 | Execute permission |

## Verification
A wrong table base or level count shows up at memAddr on the next read, one cycle after the entry that caused it is taken. It then shows as a changed memory access count or a changed physical address in the same response. A corrupted captured privilege, access kind or flag shows no earlier than the response pulse, as a fault flip or a wrong permission bit. A missing or spurious write-back shows in the bench's memory image at the write handshake, before the response. The random tables mix pointer depths, leaf flags and misaligned page numbers, so each leaf check is exercised both alone and in combination with the others.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  localparam int PAGE_OFF_W    = 12;
  localparam int PTE_PPN_LSB   = 10;
  localparam int NARROW_IDX_W  = 10;
  localparam int WIDE_IDX_W    = 9;
  localparam int NARROW_VA_W   = 32;
  localparam int WIDE_VA_W     = 39;
  localparam int NARROW_PTE_SH = 2;
  localparam int WIDE_PTE_SH   = 3;

  localparam logic [1:0] MODE_BARE        = 2'd0;
  localparam logic [1:0] MODE_TWO_LEVEL   = 2'd1;
  localparam logic [1:0] MODE_THREE_LEVEL = 2'd2;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [1:0] PRIV_USER    = 2'd0;
  localparam logic [1:0] PRIV_SUPER   = 2'd1;
  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  typedef struct packed {
    logic capture;
    logic latchPte;
    logic descend;
    logic finishPass;
    logic finishFault;
    logic finishOk;
  } walkCtrl_t;

  typedef struct packed {
    logic passThru;
    logic canonFault;
    logic pteInvalid;
    logic ptePointer;
    logic lastLevel;
    logic leafFault;
    logic needUpdate;
  } walkFlags_t;

endpackage

// File: rtl/pt_walk_datapath.sv
module pt_walk_datapath
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  walkCtrl_t                  ctrl,
  input  logic [VA_W-1:0]            reqVaddr,
  input  logic [1:0]                 reqAccess,
  input  logic [1:0]                 reqPriv,
  input  logic                       reqSupUser,
  input  logic                       reqExecRead,
  input  logic [1:0]                 walkMode,
  input  logic [PA_W-PAGE_OFF_W-1:0] rootPpn,
  input  logic [PTE_W-1:0]           memRdata,
  output walkFlags_t                 flags,
  output logic [PA_W-1:0]            memAddr,
  output logic [PTE_W-1:0]           memWdata,
  output logic                       rspFault,
  output logic [1:0]                 rspAccess,
  output logic [PA_W-1:0]            rspPaddr,
  output logic                       rspRead,
  output logic                       rspWrite,
  output logic                       rspExec
);

  localparam int PPN_W   = PA_W - PAGE_OFF_W;
  localparam int VPN_W   = VA_W - PAGE_OFF_W;
  localparam int HIGH_W  = VA_W - WIDE_VA_W + 1;
  localparam logic [NARROW_IDX_W-1:0] NARROW_MASK = '1;
  localparam logic [NARROW_IDX_W-1:0] WIDE_MASK   = NARROW_IDX_W'((1 << WIDE_IDX_W) - 1);
  localparam logic [VPN_W-1:0] NARROW_VPN_MASK    = VPN_W'((64'd1 << (NARROW_VA_W - PAGE_OFF_W)) - 1);
  localparam logic [PTE_W-1:0] NARROW_PTE_MASK    = PTE_W'(64'hFFFF_FFFF);

  logic [VA_W-1:0]  vaReg;
  logic [1:0]       accReg;
  logic [1:0]       privReg;
  logic             supUserReg;
  logic             execReadReg;
  logic [1:0]       modeReg;
  logic [PPN_W-1:0] baseReg;
  logic [1:0]       lvlReg;
  logic [PTE_W-1:0] pteReg;

  logic                    twoLevel;
  logic [VPN_W-1:0]        vpnAll;
  logic [4:0]              shiftAmt;
  logic [NARROW_IDX_W-1:0] curIdx;
  logic [PPN_W-1:0]        leafPpn;
  logic [PPN_W-1:0]        superMask;
  logic [PTE_W-1:0]        updatedPte;
  logic [HIGH_W-1:0]       highBits;
  logic                    bitR, bitW, bitX, bitU, bitD;
  logic                    reservedEnc, privFault, misaligned, accessFault;

  assign twoLevel = (modeReg == MODE_TWO_LEVEL);
  assign shiftAmt = 5'(lvlReg) * (twoLevel ? 5'(NARROW_IDX_W) : 5'(WIDE_IDX_W));

  always_comb begin
    vpnAll = vaReg[VA_W-1:PAGE_OFF_W];
    if (twoLevel) vpnAll = vpnAll & NARROW_VPN_MASK;
  end

  assign curIdx  = NARROW_IDX_W'(vpnAll >> shiftAmt) & (twoLevel ? NARROW_MASK : WIDE_MASK);
  assign memAddr = {baseReg, PAGE_OFF_W'(0)}
                 + (twoLevel ? (PA_W'(curIdx) << NARROW_PTE_SH) : (PA_W'(curIdx) << WIDE_PTE_SH));

  assign bitR = pteReg[BIT_R];
  assign bitW = pteReg[BIT_W];
  assign bitX = pteReg[BIT_X];
  assign bitU = pteReg[BIT_U];
  assign bitD = pteReg[BIT_D];

  assign leafPpn   = pteReg[PTE_PPN_LSB +: PPN_W];
  assign superMask = ~({PPN_W{1'b1}} << shiftAmt);

  assign reservedEnc = bitW && !bitR;
  assign privFault   = bitU ? ((privReg != PRIV_USER) && (!supUserReg || accReg == ACC_FETCH))
                            : (privReg != PRIV_SUPER);
  assign misaligned  = |(leafPpn & superMask);

  always_comb begin
    case (accReg)
      ACC_LOAD:  accessFault = !(bitR || (bitX && execReadReg));
      ACC_STORE: accessFault = !bitW;
      default:   accessFault = !bitX;
    endcase
  end

  always_comb begin
    updatedPte = pteReg;
    updatedPte[BIT_A] = 1'b1;
    if (accReg == ACC_STORE) updatedPte[BIT_D] = 1'b1;
  end

  assign memWdata = updatedPte;
  assign highBits = vaReg[VA_W-1:WIDE_VA_W-1];

  assign flags.passThru   = !((modeReg == MODE_TWO_LEVEL) || (modeReg == MODE_THREE_LEVEL))
                            || (privReg == PRIV_MACHINE);
  assign flags.canonFault = (modeReg == MODE_THREE_LEVEL) && !((&highBits) || !(|highBits));
  assign flags.pteInvalid = !pteReg[BIT_V];
  assign flags.ptePointer = !bitR && !bitW && !bitX;
  assign flags.lastLevel  = (lvlReg == 2'd0);
  assign flags.leafFault  = reservedEnc || privFault || misaligned || accessFault;
  assign flags.needUpdate = (updatedPte != pteReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg       <= '0;
      accReg      <= ACC_FETCH;
      privReg     <= PRIV_USER;
      supUserReg  <= 1'b0;
      execReadReg <= 1'b0;
      modeReg     <= MODE_BARE;
      baseReg     <= '0;
      lvlReg      <= '0;
      pteReg      <= '0;
    end else begin
      if (ctrl.capture) begin
        vaReg       <= reqVaddr;
        accReg      <= reqAccess;
        privReg     <= reqPriv;
        supUserReg  <= reqSupUser;
        execReadReg <= reqExecRead;
        modeReg     <= walkMode;
        baseReg     <= rootPpn;
        lvlReg      <= (walkMode == MODE_TWO_LEVEL) ? 2'd1 : 2'd2;
      end
      if (ctrl.latchPte) pteReg <= twoLevel ? (memRdata & NARROW_PTE_MASK) : memRdata;
      if (ctrl.descend) begin
        baseReg <= leafPpn;
        lvlReg  <= lvlReg - 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspFault <= 1'b0;
      rspPaddr <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
    end else if (ctrl.finishPass) begin
      rspFault <= 1'b0;
      rspPaddr <= vaReg[PA_W-1:0];
      rspRead  <= 1'b1;
      rspWrite <= 1'b1;
      rspExec  <= 1'b1;
    end else if (ctrl.finishFault) begin
      rspFault <= 1'b1;
      rspPaddr <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
    end else if (ctrl.finishOk) begin
      rspFault <= 1'b0;
      rspPaddr <= {leafPpn | (PPN_W'(vpnAll) & superMask), vaReg[PAGE_OFF_W-1:0]};
      rspRead  <= bitR || (bitX && execReadReg);
      rspWrite <= bitW && ((accReg == ACC_STORE) || bitD);
      rspExec  <= bitX;
    end
  end

  assign rspAccess = accReg;

endmodule

// File: rtl/pt_walk_control.sv
module pt_walk_control
  import pt_walk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memReady,
  input  walkFlags_t flags,
  output walkCtrl_t  ctrl,
  output logic       reqReady,
  output logic       memReq,
  output logic       memWe,
  output logic       rspValid
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_READ, ST_CHECK, ST_WRITE, ST_DONE
  } walkState_e;

  walkState_e state, nextState;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.capture = 1'b1;
          nextState    = ST_START;
        end
      end
      ST_START: begin
        if (flags.passThru) begin
          ctrl.finishPass = 1'b1;
          nextState       = ST_DONE;
        end else if (flags.canonFault) begin
          ctrl.finishFault = 1'b1;
          nextState        = ST_DONE;
        end else begin
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        if (memReady) begin
          ctrl.latchPte = 1'b1;
          nextState     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flags.pteInvalid) begin
          ctrl.finishFault = 1'b1;
          nextState        = ST_DONE;
        end else if (flags.ptePointer) begin
          if (flags.lastLevel) begin
            ctrl.finishFault = 1'b1;
            nextState        = ST_DONE;
          end else begin
            ctrl.descend = 1'b1;
            nextState    = ST_READ;
          end
        end else if (flags.leafFault) begin
          ctrl.finishFault = 1'b1;
          nextState        = ST_DONE;
        end else if (flags.needUpdate) begin
          nextState = ST_WRITE;
        end else begin
          ctrl.finishOk = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_WRITE: begin
        if (memReady) begin
          ctrl.finishOk = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_READ) || (state == ST_WRITE);
  assign memWe    = (state == ST_WRITE);
  assign rspValid = (state == ST_DONE);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [VA_W-1:0]            reqVaddr,
  input  logic [1:0]                 reqAccess,
  input  logic [1:0]                 reqPriv,
  input  logic                       reqSupUser,
  input  logic                       reqExecRead,
  input  logic [1:0]                 walkMode,
  input  logic [PA_W-PAGE_OFF_W-1:0] rootPpn,
  output logic                       memReq,
  output logic                       memWe,
  output logic [PA_W-1:0]            memAddr,
  output logic [PTE_W-1:0]           memWdata,
  input  logic                       memReady,
  input  logic [PTE_W-1:0]           memRdata,
  output logic                       rspValid,
  output logic                       rspFault,
  output logic [1:0]                 rspAccess,
  output logic [PA_W-1:0]            rspPaddr,
  output logic                       rspRead,
  output logic                       rspWrite,
  output logic                       rspExec
);

  walkCtrl_t  ctrl;
  walkFlags_t flags;

  pt_walk_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memReady (memReady),
    .flags    (flags),
    .ctrl     (ctrl),
    .reqReady (reqReady),
    .memReq   (memReq),
    .memWe    (memWe),
    .rspValid (rspValid)
  );

  pt_walk_datapath #(.VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqVaddr    (reqVaddr),
    .reqAccess   (reqAccess),
    .reqPriv     (reqPriv),
    .reqSupUser  (reqSupUser),
    .reqExecRead (reqExecRead),
    .walkMode    (walkMode),
    .rootPpn     (rootPpn),
    .memRdata    (memRdata),
    .flags       (flags),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .rspFault    (rspFault),
    .rspAccess   (rspAccess),
    .rspPaddr    (rspPaddr),
    .rspRead     (rspRead),
    .rspWrite    (rspWrite),
    .rspExec     (rspExec)
  );

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int PA_W  = 56,
  parameter int PTE_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             memReq,
  input logic             memWe,
  input logic             memReady,
  input logic [PA_W-1:0]  memAddr,
  input logic [PTE_W-1:0] memWdata,
  input logic             rspValid,
  input logic             rspFault,
  input logic [1:0]       rspAccess,
  input logic             rspRead,
  input logic             rspWrite,
  input logic             rspExec
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)); // R13

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R13

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq && !rspValid); // R13

  AST_WB_SETS_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[6]); // R9

  AST_STORE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && rspAccess == 2'd2 |-> memWdata[7]); // R9

  AST_FAULT_NO_PERMS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> !rspRead && !rspWrite && !rspExec); // R11

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> !$past(memReq)); // R9

endmodule

bind pt_walker pt_walker_checker #(.PA_W(PA_W), .PTE_W(PTE_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .memReq    (memReq),
  .memWe     (memWe),
  .memReady  (memReady),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .rspValid  (rspValid),
  .rspFault  (rspFault),
  .rspAccess (rspAccess),
  .rspRead   (rspRead),
  .rspWrite  (rspWrite),
  .rspExec   (rspExec)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic [1:0]  reqPriv = '0;
  logic        reqSupUser = 1'b0;
  logic        reqExecRead = 1'b0;
  logic [1:0]  walkMode = '0;
  logic [43:0] rootPpn = '0;
  logic        memReq, memWe;
  logic [55:0] memAddr;
  logic [63:0] memWdata;
  logic        memReady = 1'b0;
  logic [63:0] memRdata = '0;
  logic        rspValid, rspFault, rspRead, rspWrite, rspExec;
  logic [1:0]  rspAccess;
  logic [55:0] rspPaddr;

  pt_walker u_pt_walker (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  bit [63:0] memArr [bit [55:0]];
  int        accCnt;
  bit        wrSeen;
  bit [55:0] wrAddr;
  bit [63:0] wrData;

  bit        expFault, expR, expW, expX, expWrote;
  bit [55:0] expPa, expWrAddr;
  bit [63:0] expWrData;
  int        expAcc;

  function automatic bit [63:0] rdMem(bit [55:0] a);
    return memArr.exists(a) ? memArr[a] : 64'd0;
  endfunction

  function automatic bit [55:0] slotAddr(bit [1:0] md, bit [43:0] base, bit [63:0] va, int lv);
    int ib = (md == 2'd1) ? 10 : 9;
    bit [51:0] vpn = (md == 2'd1) ? {32'd0, va[31:12]} : va[63:12];
    int idx = int'((vpn >> (lv * ib)) & 52'((1 << ib) - 1));
    return {base, 12'h000} + 56'(idx * ((md == 2'd1) ? 4 : 8));
  endfunction

  function automatic bit [63:0] mkPte(bit [43:0] ppn, bit [7:0] fl);
    return {10'd0, ppn, 2'd0, fl};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(bit ok, string req, string what, bit [63:0] act, bit [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: random latency, one-cycle ready
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      memReady = 1'b0;
      if (memReq) begin
        if (waitCnt == 0) begin
          memReady = 1'b1;
          memRdata = rdMem(memAddr);
          accCnt++;
          if (memWe) begin
            memArr[memAddr] = memWdata;
            wrSeen = 1'b1;
            wrAddr = memAddr;
            wrData = memWdata;
          end
          waitCnt = int'($urandom % 3);
        end else begin
          waitCnt--;
        end
      end
    end
  end

  // reference model built from the requirements
  task automatic predict(bit [1:0] md, bit [43:0] root, bit [63:0] va, bit [1:0] acc,
                         bit [1:0] prv, bit su, bit xr);
    int ib, levels, sh;
    bit [43:0] base, ppn, smask;
    bit [51:0] vpn;
    bit [63:0] pte, upd;
    bit [55:0] a;
    bit rsv, pf, mis, af;
    expFault = 0; expPa = 0; expR = 0; expW = 0; expX = 0;
    expWrote = 0; expWrAddr = 0; expWrData = 0; expAcc = 0;
    if (!(md == 2'd1 || md == 2'd2) || prv == 2'd3) begin
      expPa = va[55:0]; expR = 1; expW = 1; expX = 1;
      return;
    end
    if (md == 2'd2 && !((&va[63:38]) || !(|va[63:38]))) begin
      expFault = 1;
      return;
    end
    levels = (md == 2'd1) ? 2 : 3;
    ib     = (md == 2'd1) ? 10 : 9;
    vpn    = (md == 2'd1) ? {32'd0, va[31:12]} : va[63:12];
    base   = root;
    for (int lv = levels - 1; lv >= 0; lv--) begin
      a = slotAddr(md, base, va, lv);
      pte = rdMem(a);
      if (md == 2'd1) pte[63:32] = 32'd0;
      expAcc++;
      ppn = pte[53:10];
      if (!pte[0]) begin expFault = 1; return; end
      if (!pte[1] && !pte[2] && !pte[3]) begin
        if (lv == 0) begin expFault = 1; return; end
        base = ppn;
        continue;
      end
      sh    = lv * ib;
      smask = (44'd1 << sh) - 44'd1;
      rsv   = !pte[1] && pte[2];
      pf    = pte[4] ? (prv != 2'd0 && (!su || acc == 2'd0)) : (prv != 2'd1);
      mis   = (ppn & smask) != 44'd0;
      af    = (acc == 2'd1) ? !(pte[1] || (pte[3] && xr)) :
              (acc == 2'd2) ? !pte[2] : !pte[3];
      if (rsv || pf || mis || af) begin expFault = 1; return; end
      upd = pte | 64'h40 | ((acc == 2'd2) ? 64'h80 : 64'h0);
      if (upd != pte) begin
        expWrote = 1; expWrAddr = a; expWrData = upd; expAcc++;
      end
      expPa = {ppn | (vpn[43:0] & smask), va[11:0]};
      expR  = pte[1] || (pte[3] && xr);
      expX  = pte[3];
      expW  = pte[2] && (acc == 2'd2 || pte[7]);
      return;
    end
  endtask

  task automatic doWalk(string tag, bit [1:0] md, bit [43:0] root, bit [63:0] va,
                        bit [1:0] acc, bit [1:0] prv, bit su, bit xr);
    int guard = 0;
    predict(md, root, va, acc, prv, su, xr);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    accCnt = 0; wrSeen = 0;
    reqValid = 1; reqVaddr = va; reqAccess = acc; reqPriv = prv;
    reqSupUser = su; reqExecRead = xr; walkMode = md; rootPpn = root;
    @(negedge clk);
    reqValid = 0;
    while (!rspValid && guard < 200) begin @(negedge clk); guard++; end
    check(rspValid, "R13", "response arrives", 64'(rspValid), 64'd1);
    check(rspFault == expFault, tag, "fault", 64'(rspFault), 64'(expFault));
    check(rspAccess == acc, "R12", "access echoed", 64'(rspAccess), 64'(acc));
    check(accCnt == expAcc, "R3", "memory access count", 64'(accCnt), 64'(expAcc));
    check(wrSeen == expWrote, "R9", "write-back issued", 64'(wrSeen), 64'(expWrote));
    if (expWrote && wrSeen) begin
      check(wrAddr == expWrAddr, "R9", "write-back address", 64'(wrAddr), 64'(expWrAddr));
      check(wrData == expWrData, "R9", "write-back data", wrData, expWrData);
    end
    if (!expFault) check(rspPaddr == expPa, "R10", "physical address", 64'(rspPaddr), 64'(expPa));
    check({rspRead, rspWrite, rspExec} == {expR, expW, expX}, "R11", "permissions",
          64'({rspRead, rspWrite, rspExec}), 64'({expR, expW, expX}));
    @(negedge clk);
    check(!rspValid, "R13", "response is one pulse", 64'(rspValid), 64'd0);
  endtask

  task automatic buildChain(bit [1:0] md, bit [43:0] root, bit [63:0] va, int leafLv,
                            bit [43:0] leafPpn, bit [7:0] fl);
    bit [43:0] base = root;
    bit [43:0] nxt;
    int levels = (md == 2'd1) ? 2 : 3;
    memArr.delete();
    for (int lv = levels - 1; lv >= leafLv; lv--) begin
      if (lv == leafLv) begin
        memArr[slotAddr(md, base, va, lv)] = mkPte(leafPpn, fl);
      end else begin
        nxt = (md == 2'd1) ? ((base + 44'h11) & 44'h3F_FFFF) : base + 44'h11;
        memArr[slotAddr(md, base, va, lv)] = mkPte(nxt, 8'h01);
        base = nxt;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit [63:0] va;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !memReq, "R13", "reset state",
          64'({reqReady, rspValid, memReq}), 64'b100);

    // R1: bare mode and machine privilege
    memArr.delete();
    doWalk("R1", 2'd0, 44'h5, 64'h1234_5678_9ABC_DEF0, 2'd1, 2'd0, 0, 0);
    doWalk("R1", 2'd2, 44'h5, 64'hFFFF_FFC0_0000_1234, 2'd2, 2'd3, 0, 0);
    // R2: non-canonical in three-level mode
    doWalk("R2", 2'd2, 44'h5, 64'h0000_0040_0000_0000, 2'd1, 2'd1, 0, 0);
    // R3 / R9 / R10: two-level store sets A and D; upper VA bits ignored (R2)
    va = 64'hDEAD_0000_0040_3123;
    buildChain(2'd1, 44'h100, va, 0, 44'h345, 8'h07);
    doWalk("R9", 2'd1, 44'h100, va, 2'd2, 2'd1, 0, 0);
    check(memArr[slotAddr(2'd1, 44'h111, va, 0)] == mkPte(44'h345, 8'hC7), "R9", "stored entry",
          memArr[slotAddr(2'd1, 44'h111, va, 0)], mkPte(44'h345, 8'hC7));
    doWalk("R9", 2'd1, 44'h100, va, 2'd1, 2'd1, 0, 0);
    // R10 / R7: three-level superpage at level 1
    va = 64'h0000_0000_00A7_7ABC;
    buildChain(2'd2, 44'h10, va, 1, 44'h400, 8'h4B);
    doWalk("R10", 2'd2, 44'h10, va, 2'd0, 2'd1, 0, 0);
    buildChain(2'd2, 44'h10, va, 1, 44'h401, 8'h4B);
    doWalk("R7", 2'd2, 44'h10, va, 2'd0, 2'd1, 0, 0);
    // R4: invalid top entry; pointer at last level
    memArr.delete();
    doWalk("R4", 2'd2, 44'h10, va, 2'd1, 2'd1, 0, 0);
    buildChain(2'd1, 44'h20, va, 0, 44'h30, 8'h01);
    doWalk("R4", 2'd1, 44'h20, va, 2'd1, 2'd1, 0, 0);
    // R5: reserved encodings
    buildChain(2'd1, 44'h20, va, 0, 44'h30, 8'h05);
    doWalk("R5", 2'd1, 44'h20, va, 2'd2, 2'd1, 0, 0);
    buildChain(2'd1, 44'h20, va, 0, 44'h30, 8'h0D);
    doWalk("R5", 2'd1, 44'h20, va, 2'd0, 2'd1, 0, 0);
    // R6: user pages from supervisor, supervisor page from user
    buildChain(2'd2, 44'h40, va, 0, 44'h55, 8'h1B);
    doWalk("R6", 2'd2, 44'h40, va, 2'd1, 2'd1, 0, 0);
    doWalk("R6", 2'd2, 44'h40, va, 2'd1, 2'd1, 1, 0);
    doWalk("R6", 2'd2, 44'h40, va, 2'd0, 2'd1, 1, 0);
    doWalk("R6", 2'd2, 44'h40, va, 2'd1, 2'd0, 0, 0);
    buildChain(2'd2, 44'h40, va, 0, 44'h55, 8'h0B);
    doWalk("R6", 2'd2, 44'h40, va, 2'd1, 2'd0, 0, 0);
    // R8 / R11: execute-only page loads
    buildChain(2'd2, 44'h40, va, 0, 44'h55, 8'h49);
    doWalk("R8", 2'd2, 44'h40, va, 2'd1, 2'd1, 0, 0);
    doWalk("R8", 2'd2, 44'h40, va, 2'd1, 2'd1, 0, 1);
    // R11: writable clean page on a load grants no write
    buildChain(2'd2, 44'h40, va, 0, 44'h55, 8'h47);
    doWalk("R11", 2'd2, 44'h40, va, 2'd1, 2'd1, 0, 0);

    // random tables
    for (int t = 0; t < 400; t++) begin
      bit [1:0]  md   = ($urandom % 2) ? 2'd2 : 2'd1;
      int        lvls = (md == 2'd1) ? 2 : 3;
      int        ib   = (md == 2'd1) ? 10 : 9;
      int        leafLv = int'($urandom % lvls);
      bit [43:0] root, lp;
      bit [7:0]  fl;
      bit [1:0]  acc  = 2'($urandom % 3);
      int        pick = int'($urandom % 4);
      bit [1:0]  prv  = (pick == 3) ? 2'd3 : ((pick == 0) ? 2'd0 : 2'd1);
      bit [63:0] rva  = {$urandom, $urandom};
      if (md == 2'd1) begin
        root = 44'($urandom & 32'h3F_FFFF);
        lp   = 44'($urandom & 32'h3F_FFFF);
      end else begin
        root = {12'($urandom), $urandom};
        lp   = {12'($urandom), $urandom};
        if ($urandom % 10 != 0) rva[63:39] = {25{rva[38]}};
      end
      if ($urandom % 2) lp = lp & ~((44'd1 << (leafLv * ib)) - 44'd1);
      fl = 8'($urandom);
      if ($urandom % 8 != 0) fl[0] = 1'b1;
      buildChain(md, root, rva, leafLv, lp, fl);
      doWalk("R8", md, root, rva, acc, prv, 1'($urandom), 1'($urandom));
    end

    summary();
    $finish;
  end

endmodule